// File: doc/BRIEF.md
# Four-Way Set-Associative Tag Store with Clean-First Replacement

This block holds the tags of a 32 KB, 4-way set-associative cache with 16-byte lines: 2048 lines in 512 sets. Each way of each set keeps a tag, a valid bit and a dirty bit. A lookup splits a 32-bit byte address into tag, set index and byte offset. It compares the tag against the four ways of the selected set at once, with one comparator per way. The lookup answers with the hit flag, the one-hot hit way, and the dirty state of the hit line. The same response also names the way that a fill to this set would replace now, whether that way holds modified data, and its stored tag. With these the requester can plan a write-back before it refills the line.

Lookups enter through a valid/ready request channel and leave through a valid/ready response channel. A request is taken on a clock edge where `lk_valid` and `lk_ready` are both high. Its response appears on the next cycle and stays unchanged until `rsp_ready` takes it. While a response is waiting, `lk_ready` follows `rsp_ready`, so a stalled consumer stops new requests without any loss. The fill port writes a new tag into the set. It is always accepted in a single cycle and has priority over a lookup in the same cycle. Data storage, refill sequencing and the memory side belong to other blocks.

The block chooses the victim separately for each set. An empty way is chosen first. If there is none, the least recently used clean way is chosen, which avoids a write-back. Only when every way is dirty does the plain least recently used way go. Each set keeps its own true recency order as a 2-bit age per way.

Top module: `sat_tag_array`

## Requirements
- R1: Address bits [3:0] are the byte offset and are ignored. Bits [12:4] select one of 512 sets. Bits [31:13] are the 19-bit tag.
- R2: A lookup hits when a valid way of the addressed set holds its tag. The response gives `rsp_hit`=1, `rsp_way` one-hot with bit n for way n, and `rsp_dirty` equal to that line's dirty bit before this access.
- R3: A lookup that matches no valid way responds with `rsp_hit`=0, `rsp_way`=0 and `rsp_dirty`=0.
- R4: Each accepted lookup gives exactly one response, valid in the cycle after acceptance, in request order. The response is held stable while `rsp_ready` is low. `lk_ready` is high exactly when no response is pending or `rsp_ready` is high, and `fl_valid` is low.
- R5: A fill is always accepted (`fl_ready`=1). It installs the tag of `fl_addr` in the chosen way of its set, marks that way valid and clean, and takes priority over a lookup in the same cycle.
- R6: A lookup with `lk_write`=1 that hits sets the dirty bit of the hit line. A write lookup that misses changes no valid, dirty, tag or recency state.
- R7: The victim (`rsp_vic_way`, one-hot) is the lowest-numbered invalid way when the set has one.
- R8: When all four ways are valid, the victim is the least recently used clean way. If all four are dirty, it is the least recently used way. `rsp_vic_dirty` is 1 exactly when the victim is valid and dirty, and `rsp_vic_tag` is its stored tag.
- R9: A lookup hit or a fill makes that way the most recently used of its set; a lookup miss leaves recency unchanged. After reset, every set ranks way 0 as most recent and way 3 as least recent.
- R10: A fill whose tag already sits in a valid way of the set rewrites that way, so at most one way of a set ever matches a tag.
- R11: After reset every way of every set is invalid and clean, and no response is pending.
- R12: Each set keeps its own valid, dirty, tag and recency state; activity on one set leaves every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be taken |
| lk_addr | input | 32 | Lookup byte address |
| lk_write | input | 1 | Lookup is a store; marks a hit line dirty |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 4 | One-hot hit way, zero on a miss |
| rsp_dirty | output | 1 | Hit line was dirty before the access |
| rsp_vic_way | output | 4 | One-hot way that a fill would replace |
| rsp_vic_dirty | output | 1 | Victim holds modified data |
| rsp_vic_tag | output | 19 | Tag stored in the victim way |
| fl_valid | input | 1 | Fill request valid |
| fl_ready | output | 1 | Fill accepted (always high) |
| fl_addr | input | 32 | Address of the line being installed |

## Verification
The hardest state to reach is a full set where clean and dirty lines are mixed across different ages. Only then does the clean-first rule choose a way other than the least recently used one. The same goes for a set where every line is dirty. Directed steps fill one set completely, dirty chosen ways with write hits, and reorder recency with further hits before they ask for the victim. A long random phase then works a handful of sets from a small tag pool while stalling the response channel at random. A reference model built from the rules above predicts every response.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int ADDR_W     = 32;
  localparam int LINE_BYTES = 16;
  localparam int NUM_LINES  = 2048;
  localparam int NUM_WAYS   = 4;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int NUM_SETS   = NUM_LINES / NUM_WAYS;
  localparam int IDX_W      = $clog2(NUM_SETS);
  localparam int TAG_W      = ADDR_W - IDX_W - OFF_W;
  localparam int AGE_W      = $clog2(NUM_WAYS);
endpackage

// File: rtl/sat_way_store.sv
module sat_way_store #(
  parameter int SETS  = 512,
  parameter int IDX_W = 9,
  parameter int TAG_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] cmp_tag,
  input  logic             fill_en,
  input  logic             mark_dirty,
  output logic             o_valid,
  output logic             o_dirty,
  output logic [TAG_W-1:0] o_tag,
  output logic             o_match
);
  logic [SETS-1:0]  vld_q;
  logic [SETS-1:0]  drt_q;
  logic [TAG_W-1:0] tag_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      drt_q <= '0;
    end else if (fill_en) begin
      vld_q[rd_idx] <= 1'b1;
      drt_q[rd_idx] <= 1'b0;
    end else if (mark_dirty) begin
      drt_q[rd_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[rd_idx] <= cmp_tag;
  end

  assign o_valid = vld_q[rd_idx];
  assign o_dirty = drt_q[rd_idx];
  assign o_tag   = tag_q[rd_idx];
  assign o_match = o_valid && (o_tag == cmp_tag);

  // R5: a fill leaves the line valid, clean and holding the new tag
  a_r5_fill_installs: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> vld_q[$past(rd_idx)] && !drt_q[$past(rd_idx)] &&
                (tag_q[$past(rd_idx)] == $past(cmp_tag)));

  // R6: only a valid line can be marked dirty, and the mark sticks
  a_r6_dirty_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    mark_dirty |-> o_valid);
  a_r6_dirty_set: assert property (@(posedge clk) disable iff (!rst_n)
    mark_dirty |=> drt_q[$past(rd_idx)]);
endmodule

// File: rtl/sat_age_store.sv
module sat_age_store #(
  parameter int SETS  = 512,
  parameter int WAYS  = 4,
  parameter int IDX_W = 9,
  parameter int AGE_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [IDX_W-1:0]           rd_idx,
  input  logic                       touch_en,
  input  logic [AGE_W-1:0]           touch_way,
  output logic [WAYS-1:0][AGE_W-1:0] o_age
);
  logic [WAYS-1:0][AGE_W-1:0] age_q [SETS];
  logic [WAYS-1:0]            seen;

  assign o_age = age_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= AGE_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (AGE_W'(w) == touch_way)
          age_q[rd_idx][w] <= '0;
        else if (o_age[w] < o_age[touch_way])
          age_q[rd_idx][w] <= o_age[w] + 1'b1;
      end
    end
  end

  always_comb begin
    seen = '0;
    for (int w = 0; w < WAYS; w++) seen[o_age[w]] = 1'b1;
  end

  // R9: ages of a set always form a permutation
  a_r9_age_perm: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seen) == WAYS);
  // R9: the touched way becomes most recent
  a_r9_touch_mru: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> age_q[$past(rd_idx)][$past(touch_way)] == '0);
endmodule

// File: rtl/sat_victim_sel.sv
module sat_victim_sel #(
  parameter int WAYS  = 4,
  parameter int AGE_W = 2
) (
  input  logic [WAYS-1:0]            valid,
  input  logic [WAYS-1:0]            dirty,
  input  logic [WAYS-1:0][AGE_W-1:0] age,
  output logic [WAYS-1:0]            victim
);
  logic             got_free;
  logic             got_clean;
  logic [AGE_W-1:0] best_age;
  logic [WAYS-1:0]  clean_pick;

  always_comb begin
    victim     = '0;
    got_free   = 1'b0;
    got_clean  = 1'b0;
    best_age   = '0;
    clean_pick = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!got_free && !valid[w]) begin
        victim[w] = 1'b1;
        got_free  = 1'b1;
      end
    end
    for (int w = 0; w < WAYS; w++) begin
      if (valid[w] && !dirty[w] && (!got_clean || age[w] > best_age)) begin
        clean_pick    = '0;
        clean_pick[w] = 1'b1;
        best_age      = age[w];
        got_clean     = 1'b1;
      end
    end
    if (!got_free) begin
      if (got_clean) begin
        victim = clean_pick;
      end else begin
        for (int w = 0; w < WAYS; w++)
          if (age[w] == AGE_W'(WAYS - 1)) victim[w] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sat_tag_array.sv
module sat_tag_array #(
  parameter int ADDR_W     = sat_pkg::ADDR_W,
  parameter int LINE_BYTES = sat_pkg::LINE_BYTES,
  parameter int NUM_LINES  = sat_pkg::NUM_LINES,
  parameter int NUM_WAYS   = sat_pkg::NUM_WAYS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_valid,
  output logic                lk_ready,
  input  logic [ADDR_W-1:0]   lk_addr,
  input  logic                lk_write,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic                rsp_hit,
  output logic [NUM_WAYS-1:0] rsp_way,
  output logic                rsp_dirty,
  output logic [NUM_WAYS-1:0] rsp_vic_way,
  output logic                rsp_vic_dirty,
  output logic [ADDR_W-$clog2(NUM_LINES/NUM_WAYS)-$clog2(LINE_BYTES)-1:0] rsp_vic_tag,
  input  logic                fl_valid,
  output logic                fl_ready,
  input  logic [ADDR_W-1:0]   fl_addr
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int SETS  = NUM_LINES / NUM_WAYS;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int AGE_W = $clog2(NUM_WAYS);

  logic [ADDR_W-1:0] sel_addr;
  logic [IDX_W-1:0]  sel_idx;
  logic [TAG_W-1:0]  sel_tag;
  logic              unused_off;
  logic              lk_fire;

  logic [NUM_WAYS-1:0]            way_valid, way_dirty, way_match;
  logic [NUM_WAYS-1:0][TAG_W-1:0] way_tag;
  logic [NUM_WAYS-1:0]            victim, fill_tgt, fill_en, mark_dirty;
  logic [NUM_WAYS-1:0][AGE_W-1:0] ages;
  logic                           hit;
  logic [AGE_W-1:0]               hit_idx, fill_idx;
  logic                           touch_en;
  logic [AGE_W-1:0]               touch_way;
  logic [TAG_W-1:0]               vic_tag;

  assign fl_ready = 1'b1;
  assign lk_ready = (!rsp_valid || rsp_ready) && !fl_valid;
  assign lk_fire  = lk_valid && lk_ready;

  assign sel_addr   = fl_valid ? fl_addr : lk_addr;
  assign sel_idx    = sel_addr[OFF_W +: IDX_W];
  assign sel_tag    = sel_addr[ADDR_W-1 -: TAG_W];
  assign unused_off = ^sel_addr[OFF_W-1:0];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    sat_way_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_idx     (sel_idx),
      .cmp_tag    (sel_tag),
      .fill_en    (fill_en[w]),
      .mark_dirty (mark_dirty[w]),
      .o_valid    (way_valid[w]),
      .o_dirty    (way_dirty[w]),
      .o_tag      (way_tag[w]),
      .o_match    (way_match[w])
    );
    assign fill_en[w]    = fl_valid && fill_tgt[w];
    assign mark_dirty[w] = lk_fire && lk_write && way_match[w];
  end

  sat_age_store #(.SETS(SETS), .WAYS(NUM_WAYS), .IDX_W(IDX_W), .AGE_W(AGE_W)) u_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (sel_idx),
    .touch_en  (touch_en),
    .touch_way (touch_way),
    .o_age     (ages)
  );

  sat_victim_sel #(.WAYS(NUM_WAYS), .AGE_W(AGE_W)) u_vic (
    .valid  (way_valid),
    .dirty  (way_dirty),
    .age    (ages),
    .victim (victim)
  );

  assign hit      = |way_match;
  assign fill_tgt = hit ? way_match : victim;

  always_comb begin
    hit_idx  = '0;
    fill_idx = '0;
    vic_tag  = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (way_match[w]) hit_idx  = AGE_W'(w);
      if (fill_tgt[w])  fill_idx = AGE_W'(w);
      if (victim[w])    vic_tag  = way_tag[w];
    end
  end

  assign touch_en  = fl_valid || (lk_fire && hit);
  assign touch_way = fl_valid ? fill_idx : hit_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_way       <= '0;
      rsp_dirty     <= 1'b0;
      rsp_vic_way   <= '0;
      rsp_vic_dirty <= 1'b0;
      rsp_vic_tag   <= '0;
    end else if (lk_fire) begin
      rsp_valid     <= 1'b1;
      rsp_hit       <= hit;
      rsp_way       <= way_match;
      rsp_dirty     <= |(way_match & way_dirty);
      rsp_vic_way   <= victim;
      rsp_vic_dirty <= |(victim & way_valid & way_dirty);
      rsp_vic_tag   <= vic_tag;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R10: comparators of separate ways never agree on one tag
  a_r10_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_match));
  // R7: exactly one victim, and never a valid way while an empty one exists
  a_r7_victim_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(victim));
  a_r7_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
    (way_valid != '1) |-> ((victim & way_valid) == '0));
  // R4: a stalled response holds its contents
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable({rsp_hit, rsp_way, rsp_dirty,
                                 rsp_vic_way, rsp_vic_dirty, rsp_vic_tag}));
  // R5: fills block lookups in the same cycle
  a_r5_fill_priority: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid |-> !lk_ready);
  // R3: a miss reports no way and no dirty line
  a_r3_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> (rsp_way == '0) && !rsp_dirty);
endmodule

// File: tb/tb_sat_tag_array.sv
`timescale 1ns/1ps
module tb_sat_tag_array;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_write = 1'b0, rsp_ready = 1'b0, fl_valid = 1'b0;
  logic [31:0] lk_addr = '0, fl_addr = '0;
  logic        lk_ready, rsp_valid, rsp_hit, rsp_dirty, rsp_vic_dirty, fl_ready;
  logic [3:0]  rsp_way, rsp_vic_way;
  logic [18:0] rsp_vic_tag;

  sat_tag_array dut (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0, stall_en = 0;

  bit          mval [512][4];
  bit          mdrt [512][4];
  logic [18:0] mtag [512][4];
  int          mage [512][4];

  typedef struct packed {
    logic hit; logic [3:0] way; logic dirty;
    logic [3:0] vic; logic vdirty; logic [18:0] vtag;
  } exp_t;
  exp_t  exp_q [$];
  string lab_q [$];

  function automatic logic [31:0] mk(input logic [18:0] t, input int s, input int off);
    return {t, 9'(s), 4'(off)};
  endfunction

  function automatic int m_victim(input int s);
    int best = -1;
    for (int w = 0; w < 4; w++) if (!mval[s][w]) return w;
    for (int w = 0; w < 4; w++)
      if (!mdrt[s][w] && (best < 0 || mage[s][w] > mage[s][best])) best = w;
    if (best >= 0) return best;
    for (int w = 0; w < 4; w++) if (mage[s][w] == 3) return w;
    return 0;
  endfunction

  function automatic void m_touch(input int s, input int w);
    int a = mage[s][w];
    for (int v = 0; v < 4; v++) if (mage[s][v] < a) mage[s][v]++;
    mage[s][w] = 0;
  endfunction

  function automatic int m_find(input int s, input logic [18:0] t);
    for (int w = 0; w < 4; w++) if (mval[s][w] && mtag[s][w] == t) return w;
    return -1;
  endfunction

  task automatic check(input bit ok, input string lab, input string what);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s %s", lab, what); end
  endtask

  task automatic do_lookup(input logic [31:0] a, input bit wr, input string lab);
    int s = int'(a[12:4]);
    logic [18:0] t = a[31:13];
    int h, v;
    exp_t e;
    @(negedge clk);
    lk_addr = a; lk_write = wr; lk_valid = 1'b1;
    #1;
    while (!lk_ready) begin @(negedge clk); #1; end
    h = m_find(s, t);
    v = m_victim(s);
    e.hit = (h >= 0);
    e.way = (h >= 0) ? 4'(1 << h) : 4'b0;
    e.dirty = (h >= 0) ? mdrt[s][h] : 1'b0;
    e.vic = 4'(1 << v);
    e.vdirty = mval[s][v] && mdrt[s][v];
    e.vtag = mtag[s][v];
    exp_q.push_back(e);
    lab_q.push_back(lab);
    if (h >= 0) begin
      if (wr) mdrt[s][h] = 1'b1;
      m_touch(s, h);
    end
    @(posedge clk); #1;
    lk_valid = 1'b0;
  endtask

  task automatic do_fill(input logic [31:0] a, input string lab);
    int s = int'(a[12:4]);
    logic [18:0] t = a[31:13];
    int w;
    @(negedge clk);
    fl_addr = a; fl_valid = 1'b1;
    #1;
    check(fl_ready === 1'b1 && lk_ready === 1'b0, lab,
          $sformatf("fill handshake act fl_ready=%b lk_ready=%b exp 1/0", fl_ready, lk_ready));
    w = m_find(s, t);
    if (w < 0) w = m_victim(s);
    mval[s][w] = 1'b1; mdrt[s][w] = 1'b0; mtag[s][w] = t;
    m_touch(s, w);
    @(posedge clk); #1;
    fl_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || rsp_valid) @(negedge clk);
  endtask

  // Monitor: consumes responses and compares them with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      rsp_ready = stall_en ? ($urandom_range(3) != 0) : 1'b1;
      if (rst_n && rsp_valid && rsp_ready) begin
        exp_t e, act;
        string lab;
        act = {rsp_hit, rsp_way, rsp_dirty, rsp_vic_way, rsp_vic_dirty, rsp_vic_tag};
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", $sformatf("unexpected response act=%h exp none", act));
        end else begin
          e = exp_q.pop_front();
          lab = lab_q.pop_front();
          check(act === e, lab, $sformatf(
            "act hit=%b way=%b d=%b vic=%b vd=%b vt=%h exp hit=%b way=%b d=%b vic=%b vd=%b vt=%h",
            rsp_hit, rsp_way, rsp_dirty, rsp_vic_way, rsp_vic_dirty, rsp_vic_tag,
            e.hit, e.way, e.dirty, e.vic, e.vdirty, e.vtag));
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, act running exp finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 512; s++)
      for (int w = 0; w < 4; w++) begin
        mval[s][w] = 0; mdrt[s][w] = 0; mtag[s][w] = '0; mage[s][w] = w;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11: nothing pending after reset, lookups ready
    check(rsp_valid === 1'b0, "R11", $sformatf("rsp_valid act=%b exp 0", rsp_valid));
    check(lk_ready === 1'b1,  "R4",  $sformatf("lk_ready act=%b exp 1", lk_ready));

    // R11 R7: empty set misses, victim way 0
    do_lookup(mk(19'h1234, 5, 0), 0, "R11");
    // R5 R2: fill then hit
    do_fill(mk(19'h1234, 5, 0), "R5");
    do_lookup(mk(19'h1234, 5, 0), 0, "R2");
    // R1: different byte offset, same line, still hits
    do_lookup(mk(19'h1234, 5, 15), 0, "R1");
    // R1: neighbouring set or tag bit flipped misses
    do_lookup(mk(19'h1234, 4, 0), 0, "R1");
    do_lookup(mk(19'h1235, 5, 0), 0, "R1");
    // R6: write hit marks dirty, reported on next hit
    do_lookup(mk(19'h1234, 5, 3), 1, "R6");
    do_lookup(mk(19'h1234, 5, 0), 0, "R6");
    // R6: write miss has no effect
    do_lookup(mk(19'h0777, 5, 0), 1, "R6");
    do_lookup(mk(19'h0777, 5, 0), 0, "R6");
    // R7: remaining empty ways taken in order
    do_fill(mk(19'h0001, 5, 0), "R7");
    do_lookup(mk(19'h0002, 5, 0), 0, "R7");
    do_fill(mk(19'h0002, 5, 0), "R7");
    do_fill(mk(19'h0003, 5, 0), "R7");
    // R8: full set, way 0 dirty and oldest: clean LRU chosen instead
    do_lookup(mk(19'h0009, 5, 0), 0, "R8");
    // R9: hit reorders recency, victim follows
    do_lookup(mk(19'h0001, 5, 0), 0, "R9");
    do_lookup(mk(19'h0009, 5, 0), 0, "R9");
    // R8: make every way dirty, victim is plain LRU with write-back
    do_lookup(mk(19'h0001, 5, 0), 1, "R8");
    do_lookup(mk(19'h0002, 5, 0), 1, "R8");
    do_lookup(mk(19'h0003, 5, 0), 1, "R8");
    do_lookup(mk(19'h0009, 5, 0), 0, "R8");
    do_fill(mk(19'h0009, 5, 0), "R8");
    do_lookup(mk(19'h0009, 5, 0), 0, "R8");
    // R10: refilling a present tag reuses its way and cleans it
    do_fill(mk(19'h0002, 5, 0), "R10");
    do_lookup(mk(19'h0002, 5, 0), 0, "R10");
    // R12: other sets untouched
    do_lookup(mk(19'h0002, 6, 0), 0, "R12");
    do_lookup(mk(19'h0002, 511, 0), 0, "R12");
    drain();

    // R4 R2 R3 R8 R9: random traffic under back-pressure
    stall_en = 1;
    for (int i = 0; i < 3000; i++) begin
      int sidx[5] = '{0, 1, 2, 3, 511};
      int s = sidx[$urandom_range(4)];
      logic [18:0] t = 19'($urandom_range(5)) + 19'h40;
      logic [31:0] a = mk(t, s, $urandom_range(15));
      if ($urandom_range(3) == 0) do_fill(a, "R9");
      else do_lookup(a, $urandom_range(1), "R4");
    end
    drain();
    stall_en = 0;
    repeat (4) @(negedge clk);
    check(rsp_valid === 1'b0 && exp_q.size() == 0, "R4",
          $sformatf("leftover act rsp_valid=%b q=%0d exp 0/0", rsp_valid, exp_q.size()));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule